// File: doc/BRIEF.md
# Daisy-Chain Serial Response Shifter

This block is the serial output stage of a small SPI slave (mode 0: data sampled on the SCK rising edge, changed on the falling edge). It holds a 16-bit shift register that takes in SDI on every rising edge. It puts on SDO the bit it received sixteen rising edges earlier. Identical slaves can therefore share chip select and clock, with each slave's SDO wired to the next slave's SDI. The host sends one 16-bit command per slave, starting with the command for the slave at the far end. When chip select rises, every slave acts on the 16 bits it holds at that moment.

When the word held at chip-select rise is a read command, the block loads a response word in place of clearing its register. That response is shifted out during the following frame, which the host fills with no-operation words. For this the block asks the register file for data through a combinational read port (address out, data in). It also drives SDO either as a push-pull output or as an open-drain output, and leaves it undriven whenever chip select is high.

SCK, chip select and SDI are assumed to be already synchronised to `clk`, which must run at least four times faster than SCK.

Top module: `sdo_chain_shifter`

## Requirements
- R1: The SDO value changes only on a clock where an SCK falling edge or a chip-select falling edge is seen. It stays stable while SCK is high.
- R2: While chip select is high, `sdo_oe` is 0, so SDO is high impedance.
- R3: With `od_mode` = 0 (push-pull), during a frame `sdo_oe` is 1 and `sdo_out` equals the current serial bit.
- R4: With `od_mode` = 1 (open drain), during a frame `sdo_oe` is 1 with `sdo_out` = 0 only when the serial bit is 0. A 1 bit is released (`sdo_oe` = 0).
- R5: When no loaded response is left to send, the SDO bit presented for SCK rising edge n (counted from 1 within the frame, n > 16) equals the SDI bit taken on rising edge n-16.
- R6: When nothing was loaded at the previous chip-select rise, the first 16 SDO bits of a frame are 0.
- R7: At chip-select rise, suppose at least 16 bits were received and the top 3 bits of the last 16 are 100. Then the register is loaded with 111, the 5-bit address field (bits 12..8 of the command), and the 8 bits returned on `rd_data` for that address.
- R8: When the top 3 bits are 001 (control-register read), `rd_addr` is 10000b and the loaded response carries 10000b in its address field.
- R9: At chip-select rise with any other opcode, or with fewer than 16 bits received in the frame, the register is cleared.
- R10: A loaded response leaves SDO most significant bit first. The bit for rising edge 1 is presented from the chip-select falling edge onward.
- R11: With three slaves chained, a no-operation frame after a read frame brings the responses to the host in the order far end, middle, first.
- R12: After reset, SDO is high impedance and the register is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Serial data in |
| od_mode | input | 1 | 1 selects open-drain SDO, 0 push-pull |
| rd_addr | output | 5 | Register address for the response lookup |
| rd_data | input | 8 | Register contents for `rd_addr`, combinational |
| sdo_out | output | 1 | SDO drive level |
| sdo_oe | output | 1 | SDO drive enable |

## Verification
The hardest case to reach is a response from the first slave reaching the host. It must pass unchanged through two other slaves, each of which is at the same time sending its own response and counting its own frame. The bench chains three instances through pull-up resolved links. It follows every read frame with a no-operation frame, so each response crosses the whole chain. It also mixes in frames of 8, 16, 24 and 56 bits, so that commits happen with short or misaligned words and with open-drain links.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int OP_W   = 3;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int WORD_W = OP_W + ADDR_W + DATA_W;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'h10;
  localparam logic [OP_W-1:0]   RESP_TAG  = 3'b111;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE    = 3'b000,
    OP_CTRL_RD = 3'b001,
    OP_CTRL_WR = 3'b011,
    OP_REG_RD  = 3'b100,
    OP_REG_WR  = 3'b110
  } chain_op_e;

  // opcode classes that load a response at commit
  function automatic logic op_is_read(input logic [OP_W-1:0] op);
    return (op == OP_REG_RD) || (op == OP_CTRL_RD);
  endfunction

  // control-register reads ignore the address field
  function automatic logic [ADDR_W-1:0] op_addr(input logic [OP_W-1:0] op,
                                                input logic [ADDR_W-1:0] field);
    return (op == OP_CTRL_RD) ? CTRL_ADDR : field;
  endfunction

  function automatic logic [WORD_W-1:0] pack_resp(input logic [ADDR_W-1:0] addr,
                                                  input logic [DATA_W-1:0] data);
    return {RESP_TAG, addr, data};
  endfunction
endpackage

// File: rtl/spi_edge_tracker.sv
module spi_edge_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic cs_fall,
  output logic frame_active
);
  logic sck_q;
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q        <= 1'b0;
      cs_q         <= 1'b1;
      frame_active <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_fall)      frame_active <= 1'b1;
      else if (cs_rise) frame_active <= 1'b0;
    end
  end

  assign sck_rise = sck & ~sck_q & ~cs_n;
  assign sck_fall = ~sck & sck_q & ~cs_n;
  assign cs_rise  = cs_n & ~cs_q;
  assign cs_fall  = ~cs_n & cs_q;

  // R2
  frame_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !frame_active);
endmodule

// File: rtl/chain_shift_core.sv
module chain_shift_core #(
  parameter int WORD_W = spi_chain_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_rise,
  input  logic              cs_fall,
  input  logic              sdi,
  input  logic              preload_en,
  input  logic [WORD_W-1:0] preload_word,
  output logic [WORD_W-1:0] word,
  output logic              full,
  output logic              sdo_bit
);
  localparam int               CNT_W   = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      cnt     <= '0;
      sdo_bit <= 1'b0;
    end else if (cs_rise) begin
      word <= preload_en ? preload_word : '0;
      cnt  <= '0;
    end else if (cs_fall) begin
      cnt     <= '0;
      sdo_bit <= word[WORD_W-1];
    end else begin
      if (sck_rise) begin
        word <= {word[WORD_W-2:0], sdi};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
      if (sck_fall) sdo_bit <= word[WORD_W-1];
    end
  end

  assign full = (cnt == CNT_MAX);

  // R1
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_fall) |=> $stable(sdo_bit));

  // R9
  short_frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !full) |=> (word == '0));

  // R5
  count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> !full);
endmodule

// File: rtl/resp_builder.sv
module resp_builder
  import spi_chain_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              full,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              preload_en,
  output logic [WORD_W-1:0] preload_word
);
  logic [OP_W-1:0]   op_field;
  logic [ADDR_W-1:0] addr_field;

  always_comb begin
    op_field     = word[WORD_W-1 -: OP_W];
    addr_field   = word[DATA_W +: ADDR_W];
    rd_addr      = op_addr(op_field, addr_field);
    preload_en   = full && op_is_read(op_field);
    preload_word = pack_resp(rd_addr, rd_data);
  end
endmodule

// File: rtl/sdo_pad_drive.sv
module sdo_pad_drive (
  input  logic active,
  input  logic bit_val,
  input  logic od_mode,
  output logic sdo_out,
  output logic sdo_oe
);
  always_comb begin
    if (od_mode) begin
      sdo_out = 1'b0;
      sdo_oe  = active & ~bit_val;
    end else begin
      sdo_out = bit_val;
      sdo_oe  = active;
    end
  end
endmodule

// File: rtl/sdo_chain_shifter.sv
module sdo_chain_shifter
  import spi_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_sdi,
  input  logic              od_mode,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sdo_out,
  output logic              sdo_oe
);
  logic              sck_rise_w, sck_fall_w, cs_rise_w, cs_fall_w, active_w;
  logic              full_w, core_bit_w, preload_en_w;
  logic [WORD_W-1:0] core_word_w, preload_word_w;

  spi_edge_tracker u_edges (
    .clk          (clk),
    .rst_n        (rst_n),
    .sck          (spi_sck),
    .cs_n         (spi_cs_n),
    .sck_rise     (sck_rise_w),
    .sck_fall     (sck_fall_w),
    .cs_rise      (cs_rise_w),
    .cs_fall      (cs_fall_w),
    .frame_active (active_w)
  );

  chain_shift_core #(.WORD_W(WORD_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .sck_rise     (sck_rise_w),
    .sck_fall     (sck_fall_w),
    .cs_rise      (cs_rise_w),
    .cs_fall      (cs_fall_w),
    .sdi          (spi_sdi),
    .preload_en   (preload_en_w),
    .preload_word (preload_word_w),
    .word         (core_word_w),
    .full         (full_w),
    .sdo_bit      (core_bit_w)
  );

  resp_builder u_resp (
    .word         (core_word_w),
    .full         (full_w),
    .rd_data      (rd_data),
    .rd_addr      (rd_addr),
    .preload_en   (preload_en_w),
    .preload_word (preload_word_w)
  );

  sdo_pad_drive u_pad (
    .active  (active_w),
    .bit_val (core_bit_w),
    .od_mode (od_mode),
    .sdo_out (sdo_out),
    .sdo_oe  (sdo_oe)
  );

  // R2
  cs_idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n)) |-> !sdo_oe);

  // R7
  resp_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_w && preload_en_w) |=> (core_word_w[WORD_W-1 -: OP_W] == RESP_TAG));

  // R8
  ctrl_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_w && preload_en_w && (core_word_w[WORD_W-1 -: OP_W] == OP_CTRL_RD))
      |=> (core_word_w[DATA_W +: ADDR_W] == CTRL_ADDR));

  // R4
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (od_mode && sdo_oe) |-> !core_bit_w);
endmodule

// File: tb/sdo_chain_shifter_tb.sv
module sdo_chain_shifter_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, spi_sck, spi_cs_n, spi_sdi;
  logic [2:0] od;
  logic [4:0] ra0, ra1, ra2;
  logic [7:0] rdat0, rdat1, rdat2;
  logic       out0, out1, out2, oe0, oe1, oe2;
  logic [7:0] salt [0:2];

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  logic [15:0] wexp [0:2];
  logic        hs   [0:127];
  string       tag  [0:2];

  function automatic logic [7:0] regval(input int k, input logic [7:0] s, input logic [4:0] a);
    return 8'((int'(a) * 29) + (k * 81)) ^ s;
  endfunction

  assign rdat0 = regval(0, salt[0], ra0);
  assign rdat1 = regval(1, salt[1], ra1);
  assign rdat2 = regval(2, salt[2], ra2);

  wire link1 = oe0 ? out0 : 1'b1;
  wire link2 = oe1 ? out1 : 1'b1;
  wire host  = oe2 ? out2 : 1'b1;

  sdo_chain_shifter u_dut (.clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_sdi(spi_sdi), .od_mode(od[0]), .rd_addr(ra0), .rd_data(rdat0), .sdo_out(out0), .sdo_oe(oe0));
  sdo_chain_shifter u_dev1 (.clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_sdi(link1), .od_mode(od[1]), .rd_addr(ra1), .rd_data(rdat1), .sdo_out(out1), .sdo_oe(oe1));
  sdo_chain_shifter u_dev2 (.clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_sdi(link2), .od_mode(od[2]), .rd_addr(ra2), .rd_data(rdat2), .sdo_out(out2), .sdo_oe(oe2));

  // bit presented by device k for rising edge n (0-based): own word, then 16-bit delayed input
  function automatic logic exp_out(input int k, input int n);
    int m = n;
    for (int j = k; j >= 0; j--) begin
      if (m < 16) return wexp[j][15 - m];
      m -= 16;
    end
    return hs[m];
  endfunction

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic clock_bit(input int n);
    logic e0, eh, s_out, s_oe;
    string th;
    @(negedge clk); spi_sdi = hs[n];
    @(negedge clk);
    e0 = exp_out(0, n);
    eh = exp_out(2, n);
    th = (n < 16) ? tag[2] : (n < 48) ? "R11" : "R5";
    chk(host, eh, th, $sformatf("host bit %0d", n));
    if (od[0]) begin
      chk(oe0, ~e0, "R4", $sformatf("od enable bit %0d", n));
      if (oe0) chk(out0, 1'b0, "R4", "od level");
    end else begin
      chk(oe0, 1'b1, "R3", $sformatf("pp enable bit %0d", n));
      chk(out0, e0, (n < 16) ? tag[0] : "R5", $sformatf("dev0 bit %0d", n));
    end
    s_out = out0; s_oe = oe0;
    spi_sck = 1'b1;
    @(negedge clk);
    chk(out0, s_out, "R1", "sdo held while sck high");
    chk(oe0, s_oe, "R1", "oe held while sck high");
    @(negedge clk);
    spi_sck = 1'b0;
  endtask

  task automatic run_frame(input int len);
    logic [15:0] nw [0:2];
    logic [15:0] w;
    logic [4:0]  a;
    @(negedge clk); spi_cs_n = 1'b0;
    @(negedge clk);
    for (int n = 0; n < len; n++) clock_bit(n);
    @(negedge clk); @(negedge clk);
    // commit expectation, computed before the frame state is replaced
    for (int k = 0; k < 3; k++) begin
      w = '0;
      nw[k] = '0;
      if (len >= 16) begin
        for (int i = 0; i < 16; i++)
          w[15 - i] = (k == 0) ? hs[len - 16 + i] : exp_out(k - 1, len - 16 + i);
        if (w[15:13] == 3'b100 || w[15:13] == 3'b001) begin
          a = (w[15:13] == 3'b001) ? 5'h10 : w[12:8];
          nw[k] = {3'b111, a, regval(k, salt[k], a)};
          tag[k] = (w[15:13] == 3'b001) ? "R8/R10" : "R7/R10";
        end else tag[k] = "R6/R9";
      end else tag[k] = "R6/R9";
    end
    spi_cs_n = 1'b1;
    @(negedge clk); @(negedge clk);
    for (int k = 0; k < 3; k++) wexp[k] = nw[k];
    chk(oe0, 1'b0, "R2", "dev0 idle oe");
    chk(oe1, 1'b0, "R2", "dev1 idle oe");
    chk(oe2, 1'b0, "R2", "dev2 idle oe");
  endtask

  // command stream: far-end word first, trailing 48 bits are the three words
  task automatic load_stream(input int len, input logic [15:0] c2, input logic [15:0] c1,
                             input logic [15:0] c0);
    logic [47:0] cw;
    cw = {c2, c1, c0};
    for (int i = 0; i < len; i++) begin
      int p = len - 1 - i;
      hs[i] = (p < 48) ? cw[p] : 1'($urandom);
    end
    for (int k = 0; k < 3; k++) salt[k] = 8'($urandom);
  endtask

  function automatic logic [15:0] rand_cmd();
    case ($urandom % 5)
      0: return {3'b100, 5'($urandom), 8'($urandom)};
      1: return {3'b001, 5'($urandom), 8'($urandom)};
      2: return {3'b110, 5'($urandom), 8'($urandom)};
      3: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int lens [0:4];
    void'($urandom(32'd2024));
    lens = '{8, 16, 24, 48, 56};
    rst_n = 1'b0; spi_sck = 1'b0; spi_cs_n = 1'b1; spi_sdi = 1'b0; od = 3'b000;
    for (int k = 0; k < 3; k++) begin wexp[k] = '0; tag[k] = "R12/R6"; salt[k] = '0; end
    repeat (4) @(negedge clk);
    chk(oe0, 1'b0, "R12", "reset oe dev0");
    chk(oe2, 1'b0, "R12", "reset oe dev2");
    rst_n = 1'b1;
    @(negedge clk);
    // directed: register reads on all three, then the no-op frame brings them home
    load_stream(48, {3'b100, 5'd3, 8'h00}, {3'b100, 5'd2, 8'h00}, {3'b100, 5'd1, 8'h00});
    run_frame(48);
    load_stream(48, 16'h0, 16'h0, 16'h0);
    run_frame(48);
    // control-register reads with open-drain links
    od = 3'b111;
    load_stream(48, {3'b001, 5'h07, 8'hAA}, {3'b001, 5'h00, 8'h55}, {3'b001, 5'h1F, 8'hFF});
    run_frame(48);
    load_stream(48, 16'h0, 16'h0, 16'h0);
    run_frame(48);
    // read committed on a short frame must be dropped
    od = 3'b000;
    load_stream(48, {3'b100, 5'd1, 8'h0}, {3'b100, 5'd2, 8'h0}, {3'b100, 5'd3, 8'h0});
    run_frame(48);
    load_stream(8, 16'h0, 16'h0, {3'b100, 5'd0, 8'h0});
    run_frame(8);
    load_stream(48, 16'h0, 16'h0, 16'h0);
    run_frame(48);
    // random frames
    for (int f = 0; f < 40; f++) begin
      int len;
      len = lens[$urandom % 5];
      od  = 3'($urandom);
      load_stream(len, rand_cmd(), rand_cmd(), rand_cmd());
      run_frame(len);
      if (f % 3 == 0) begin
        load_stream(48, 16'h0, 16'h0, 16'h0);
        run_frame(48);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule